// File: doc/BRIEF.md
# UART register front end

This block is the software-visible face of a serial port that keeps no character queues of its own. On one side it takes single-beat register accesses from a simple bus: an address, an access size of one, two or four bytes, and separate read and write strobes. On the other side it talks to a byte-wide character device that signals when a received character is waiting, accepts a pop when the character is consumed, and accepts a push when software sends one.

It stores the configuration registers (control, integer and fractional baud divisor, line control, queue-level threshold, interrupt mask) and derives the flag word, the raw interrupt status and the masked interrupt status. Because there is no queue, receive is reported as either completely empty or completely full. A level interrupt output rises a fixed number of cycles after the masked status becomes nonzero and falls as soon as it is zero again. Bad accesses, including any attempt to switch on DMA, produce a one-cycle error pulse.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd_en`, and side effects (the pop, status updates) take effect at the clock edge that ends the access.

Top module: `uart_regfile`

## Requirements
- R1: After reset the control register reads 0x300, the level register 0x12, and the integer divisor, fractional divisor, line control, mask and raw status read 0; `irq_out` and `bus_err` are low.
- R2: `bus_size` 0 selects a byte, 1 a halfword, 2 or 3 a word; write data is the low bytes of `bus_wdata` zero-extended, and read data is zero above the access size.
- R3: A read of offset 0x00 returns 0 and does not pop when `chr_avail` is low; otherwise it returns `chr_rdata` zero-extended, asserts `chr_pop` for that cycle and clears raw bits 4 (receive) and 6 (receive timeout).
- R4: In the cycle after a popping read, raw bits 4 and 6 are set again if `chr_avail` is still high.
- R5: A rising edge of `chr_avail` sets raw bits 4 and 6.
- R6: A write to offset 0x00 asserts `chr_push` with `chr_wdata` equal to the low 8 bits of the write data, and leaves raw bit 5 (transmit) set.
- R7: A write to offset 0x44 clears the raw bits that are 1 in the write data; bits 4 and 6 stay set if `chr_avail` is high in that cycle.
- R8: Offset 0x18 reads bit 0 (clear to send) = 1 and bit 7 (transmit empty) = 1 always; bit 4 (receive empty) = 1 when `chr_avail` is low, bit 6 (receive full) = 1 when it is high.
- R9: Offset 0x04 always reads 0, and writes to it change no state and raise no error.
- R10: Offset 0x3C reads the raw status and offset 0x40 reads raw status AND mask (offset 0x38, 11 bits).
- R11: `irq_out` rises INT_DELAY cycles after the masked status turns nonzero, is not restarted by further status changes while waiting, and is low in any cycle where the masked status is zero.
- R12: Offset 0x48 reads 0; a write with any of bits 2:0 set pulses `bus_err` for one cycle after the access, other writes do not.
- R13: An access to an unmapped offset, a read of 0x44, or a write to 0x18, 0x3C or 0x40 reads 0 and pulses `bus_err` for one cycle after the access.
- R14: Control (0x30, 16 bits), integer divisor (0x24, 16 bits), fractional divisor (0x28, 6 bits), line control (0x2C, 8 bits), level (0x34, 6 bits) and mask (0x38, 11 bits) read back the written value truncated to their width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd_en` is high |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| chr_avail | input | 1 | Device holds a received character |
| chr_rdata | input | 8 | Received character |
| chr_pop | output | 1 | Consume the received character |
| chr_push | output | 1 | Send `chr_wdata` |
| chr_wdata | output | 8 | Character to send |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench builds the block with ADDR_W = 12 and INT_DELAY = 3. A three-cycle delay is short enough that the bench can sample the interrupt on every cycle of the wait and see that it rises on exactly the third edge, and that a second status bit arriving mid-wait does not push the rise later. The 12-bit offset space places both the mapped registers and several unmapped and unaligned offsets within reach of the error checks.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned IRQ_W  = 11;
    localparam int unsigned BIT_RX = 4;
    localparam int unsigned BIT_TX = 5;
    localparam int unsigned BIT_RT = 6;

    localparam int unsigned CTRL_W = 16;
    localparam int unsigned IBRD_W = 16;
    localparam int unsigned FBRD_W = 6;
    localparam int unsigned LCRH_W = 8;
    localparam int unsigned IFLS_W = 6;

    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
    localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;

    localparam int unsigned OFF_DATA = 'h00;
    localparam int unsigned OFF_RSR  = 'h04;
    localparam int unsigned OFF_FLAG = 'h18;
    localparam int unsigned OFF_IBRD = 'h24;
    localparam int unsigned OFF_FBRD = 'h28;
    localparam int unsigned OFF_LCRH = 'h2C;
    localparam int unsigned OFF_CTRL = 'h30;
    localparam int unsigned OFF_IFLS = 'h34;
    localparam int unsigned OFF_MASK = 'h38;
    localparam int unsigned OFF_RAW  = 'h3C;
    localparam int unsigned OFF_MIS  = 'h40;
    localparam int unsigned OFF_ICR  = 'h44;
    localparam int unsigned OFF_DMA  = 'h48;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_RSR,
        SEL_FLAG,
        SEL_IBRD,
        SEL_FBRD,
        SEL_LCRH,
        SEL_CTRL,
        SEL_IFLS,
        SEL_MASK,
        SEL_RAW,
        SEL_MIS,
        SEL_ICR,
        SEL_DMA
    } fe_sel_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [IBRD_W-1:0] ibrd;
        logic [FBRD_W-1:0] fbrd;
        logic [LCRH_W-1:0] lcrh;
        logic [IFLS_W-1:0] ifls;
        logic [IRQ_W-1:0]  mask;
        logic [IRQ_W-1:0]  raw;
        logic              avail;
        logic              recheck;
        logic              err;
    } fe_state_t;

    // Keep the low bytes selected by the access size, zero the rest.
    function automatic logic [DW-1:0] fit_size(input logic [DW-1:0] v,
                                               input logic [1:0]    sz);
        logic [DW-1:0] r;
        case (sz)
            2'd0:    r = {{(DW-8){1'b0}}, v[7:0]};
            2'd1:    r = {{(DW-16){1'b0}}, v[15:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
    import uart_fe_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output fe_sel_e           sel,
    output logic              acc_bad
);

    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
        else if (addr == ADDR_W'(OFF_RSR))  sel = SEL_RSR;
        else if (addr == ADDR_W'(OFF_FLAG)) sel = SEL_FLAG;
        else if (addr == ADDR_W'(OFF_IBRD)) sel = SEL_IBRD;
        else if (addr == ADDR_W'(OFF_FBRD)) sel = SEL_FBRD;
        else if (addr == ADDR_W'(OFF_LCRH)) sel = SEL_LCRH;
        else if (addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_IFLS)) sel = SEL_IFLS;
        else if (addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
        else if (addr == ADDR_W'(OFF_RAW))  sel = SEL_RAW;
        else if (addr == ADDR_W'(OFF_MIS))  sel = SEL_MIS;
        else if (addr == ADDR_W'(OFF_ICR))  sel = SEL_ICR;
        else if (addr == ADDR_W'(OFF_DMA))  sel = SEL_DMA;
    end

    // Unmapped offsets and wrong-direction accesses are both bad.
    always_comb begin
        acc_bad = 1'b0;
        if ((rd_en || wr_en) && sel == SEL_NONE)
            acc_bad = 1'b1;
        if (rd_en && sel == SEL_ICR)
            acc_bad = 1'b1;
        if (wr_en && (sel == SEL_FLAG || sel == SEL_RAW || sel == SEL_MIS))
            acc_bad = 1'b1;
    end

endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq #(
    parameter int unsigned INT_DELAY = 4,
    parameter int unsigned IRQ_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] masked,
    output logic             irq
);

    localparam int unsigned CNT_W = (INT_DELAY < 2) ? 1 : $clog2(INT_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INT_DELAY - 1);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (masked == '0) begin
            st_d = '0;
        end else if (!st_q.on) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.on  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.on && (masked != '0);

    assert_irq_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(masked != '0));

    assert_irq_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_fe_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned INT_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              chr_avail,
    input  logic [7:0]        chr_rdata,
    output logic              chr_pop,
    output logic              chr_push,
    output logic [7:0]        chr_wdata,
    output logic              irq_out
);

    localparam fe_state_t ST_RST = '{
        ctrl:    CTRL_RST,
        ibrd:    '0,
        fbrd:    '0,
        lcrh:    '0,
        ifls:    IFLS_RST,
        mask:    '0,
        raw:     '0,
        avail:   1'b0,
        recheck: 1'b0,
        err:     1'b0
    };

    fe_state_t        s_d, s_q;
    fe_sel_e          sel;
    logic             acc_bad;
    logic [DW-1:0]    wv;
    logic [IRQ_W-1:0] rxrt, clr, set;
    logic [DW-1:0]    rd_val;
    logic [IRQ_W-1:0] masked;

    uart_fe_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (bus_addr),
        .rd_en   (bus_rd_en),
        .wr_en   (bus_wr_en),
        .sel     (sel),
        .acc_bad (acc_bad)
    );

    always_comb begin
        wv   = fit_size(bus_wdata, bus_size);
        rxrt = '0;
        rxrt[BIT_RX] = 1'b1;
        rxrt[BIT_RT] = 1'b1;
        clr  = '0;
        set  = '0;

        s_d         = s_q;
        s_d.avail   = chr_avail;
        s_d.recheck = 1'b0;
        s_d.err     = acc_bad;

        // New character arriving
        if (chr_avail && !s_q.avail)
            set = set | rxrt;
        // Re-raise after a pop if the device still holds data
        if (s_q.recheck && chr_avail)
            set = set | rxrt;

        if (bus_rd_en && sel == SEL_DATA && chr_avail) begin
            clr         = clr | rxrt;
            s_d.recheck = 1'b1;
        end

        if (bus_wr_en) begin
            case (sel)
                SEL_DATA: set[BIT_TX] = 1'b1;
                SEL_CTRL: s_d.ctrl = wv[CTRL_W-1:0];
                SEL_IBRD: s_d.ibrd = wv[IBRD_W-1:0];
                SEL_FBRD: s_d.fbrd = wv[FBRD_W-1:0];
                SEL_LCRH: s_d.lcrh = wv[LCRH_W-1:0];
                SEL_IFLS: s_d.ifls = wv[IFLS_W-1:0];
                SEL_MASK: s_d.mask = wv[IRQ_W-1:0];
                SEL_ICR: begin
                    clr = clr | wv[IRQ_W-1:0];
                    if (chr_avail)
                        set = set | rxrt;
                end
                SEL_DMA: begin
                    if (wv[2:0] != 3'b000)
                        s_d.err = 1'b1;
                end
                default: ;
            endcase
        end

        s_d.raw = (s_q.raw & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= ST_RST;
        else        s_q <= s_d;
    end

    assign masked = s_q.raw & s_q.mask;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_DATA: rd_val = chr_avail ? {{(DW-8){1'b0}}, chr_rdata} : '0;
            SEL_FLAG: begin
                rd_val[0] = 1'b1;
                rd_val[4] = !chr_avail;
                rd_val[6] = chr_avail;
                rd_val[7] = 1'b1;
            end
            SEL_IBRD: rd_val = DW'(s_q.ibrd);
            SEL_FBRD: rd_val = DW'(s_q.fbrd);
            SEL_LCRH: rd_val = DW'(s_q.lcrh);
            SEL_CTRL: rd_val = DW'(s_q.ctrl);
            SEL_IFLS: rd_val = DW'(s_q.ifls);
            SEL_MASK: rd_val = DW'(s_q.mask);
            SEL_RAW:  rd_val = DW'(s_q.raw);
            SEL_MIS:  rd_val = DW'(masked);
            default:  rd_val = '0;
        endcase
        bus_rdata = bus_rd_en ? fit_size(rd_val, bus_size) : '0;
    end

    assign chr_pop   = bus_rd_en && sel == SEL_DATA && chr_avail;
    assign chr_push  = bus_wr_en && sel == SEL_DATA;
    assign chr_wdata = bus_wdata[7:0];
    assign bus_err   = s_q.err;

    uart_fe_irq #(.INT_DELAY(INT_DELAY), .IRQ_W(IRQ_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .masked (masked),
        .irq    (irq_out)
    );

    assert_push_sets_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chr_push |=> s_q.raw[BIT_TX]);

    assert_rise_sets_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_avail && !s_q.avail) |=> (s_q.raw[BIT_RX] && s_q.raw[BIT_RT]));

    assert_pop_clears_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_pop && s_q.avail && !s_q.recheck) |=> !s_q.raw[BIT_RX]);

    assert_err_follows_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd_en || bus_wr_en));

    assert_dma_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_W'(OFF_DMA)) |-> bus_rdata == '0);

    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((s_q.raw & s_q.mask) != '0));

endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int DLY        = 3;

    localparam logic [11:0] A_DR   = 12'h000;
    localparam logic [11:0] A_RSR  = 12'h004;
    localparam logic [11:0] A_FLG  = 12'h018;
    localparam logic [11:0] A_IBR  = 12'h024;
    localparam logic [11:0] A_FBR  = 12'h028;
    localparam logic [11:0] A_LCR  = 12'h02C;
    localparam logic [11:0] A_CTL  = 12'h030;
    localparam logic [11:0] A_LVL  = 12'h034;
    localparam logic [11:0] A_MSK  = 12'h038;
    localparam logic [11:0] A_RAW  = 12'h03C;
    localparam logic [11:0] A_MIS  = 12'h040;
    localparam logic [11:0] A_CLR  = 12'h044;
    localparam logic [11:0] A_DMA  = 12'h048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        chr_avail = 1'b0;
    logic [7:0]  chr_rdata = '0;
    logic        chr_pop;
    logic        chr_push;
    logic [7:0]  chr_wdata;
    logic        irq_out;

    int total = 0;
    int bad   = 0;

    typedef struct {
        bit          is_wr;
        logic [31:0] data;
        logic        strobe;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile #(.ADDR_W(12), .INT_DELAY(DLY)) i_uart_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .chr_avail (chr_avail),
        .chr_rdata (chr_rdata),
        .chr_pop   (chr_pop),
        .chr_push  (chr_push),
        .chr_wdata (chr_wdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever an access is on the bus.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (bus_rd_en || bus_wr_en)) begin
            if (sb.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                if (e.is_wr) begin
                    check({e.tag, " push"}, {31'd0, chr_push}, {31'd0, e.strobe});
                    if (e.strobe)
                        check({e.tag, " wdata"}, {24'd0, chr_wdata}, e.data);
                end else begin
                    check({e.tag, " rdata"}, bus_rdata, e.data);
                    check({e.tag, " pop"}, {31'd0, chr_pop}, {31'd0, e.strobe});
                end
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                          input logic ex_push, input logic [7:0] ex_b, input string tag);
        exp_t e;
        e.is_wr = 1'b1; e.data = {24'd0, ex_b}; e.strobe = ex_push; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d, input string tag);
        bus_wr(a, 2'd2, d, 1'b0, 8'd0, tag);
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] ex,
                          input logic ex_pop, input string tag);
        exp_t e;
        e.is_wr = 1'b0; e.data = ex; e.strobe = ex_pop; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        bus_addr = a; bus_size = sz; bus_rd_en = 1'b1;
        @(posedge clk); #1;
        bus_rd_en = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, input logic [31:0] ex, input string tag);
        bus_rd(a, 2'd2, ex, 1'b0, tag);
    endtask

    task automatic check_err(input logic ex, input string tag);
        @(negedge clk);
        check({tag, " err"}, {31'd0, bus_err}, {31'd0, ex});
    endtask

    task automatic check_irq(input logic ex, input string tag);
        @(negedge clk);
        check({tag, " irq"}, {31'd0, irq_out}, {31'd0, ex});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        check("R1 err after reset", {31'd0, bus_err}, 32'd0);

        // R1: reset values
        rreg(A_CTL, 32'h300, "R1 control");
        rreg(A_LVL, 32'h12,  "R1 level");
        rreg(A_IBR, 32'h0,   "R1 int divisor");
        rreg(A_FBR, 32'h0,   "R1 frac divisor");
        rreg(A_LCR, 32'h0,   "R1 line ctrl");
        rreg(A_MSK, 32'h0,   "R1 mask");
        rreg(A_RAW, 32'h0,   "R1 raw");

        // R14: stored widths
        wreg(A_CTL, 32'hFFFF_ABCD, "R14 wr control");
        rreg(A_CTL, 32'h0000_ABCD, "R14 control");
        wreg(A_IBR, 32'h0001_1234, "R14 wr int div");
        rreg(A_IBR, 32'h0000_1234, "R14 int divisor");
        wreg(A_FBR, 32'h0000_00FF, "R14 wr frac div");
        rreg(A_FBR, 32'h0000_003F, "R14 frac divisor");
        wreg(A_LCR, 32'h0000_035A, "R14 wr line");
        rreg(A_LCR, 32'h0000_005A, "R14 line ctrl");
        wreg(A_LVL, 32'h0000_00ED, "R14 wr level");
        rreg(A_LVL, 32'h0000_002D, "R14 level");
        wreg(A_MSK, 32'hFFFF_FFFF, "R14 wr mask");
        rreg(A_MSK, 32'h0000_07FF, "R14 mask");
        wreg(A_MSK, 32'h0, "R14 wr mask zero");

        // R2: access sizes
        bus_rd(A_CTL, 2'd0, 32'h0000_00CD, 1'b0, "R2 byte read");
        bus_rd(A_CTL, 2'd1, 32'h0000_ABCD, 1'b0, "R2 half read");
        bus_rd(A_CTL, 2'd3, 32'h0000_ABCD, 1'b0, "R2 size3 read");
        bus_wr(A_CTL, 2'd0, 32'h1234_5678, 1'b0, 8'd0, "R2 byte write");
        rreg(A_CTL, 32'h0000_0078, "R2 byte write result");
        bus_wr(A_IBR, 2'd1, 32'hCAFE_5678, 1'b0, 8'd0, "R2 half write");
        rreg(A_IBR, 32'h0000_5678, "R2 half write result");

        // R8 / R3: nothing available
        rreg(A_FLG, 32'h0000_0091, "R8 flags empty");
        bus_rd(A_DR, 2'd2, 32'h0, 1'b0, "R3 empty data read");
        rreg(A_RAW, 32'h0, "R3 raw after empty read");

        // R5: arrival sets receive bits
        chr_rdata = 8'hA5;
        chr_avail = 1'b1;
        rreg(A_RAW, 32'h0000_0050, "R5 raw after arrival");
        rreg(A_FLG, 32'h0000_00C1, "R8 flags full");

        // R3: pop, device then empty
        bus_rd(A_DR, 2'd2, 32'h0000_00A5, 1'b1, "R3 data read");
        chr_avail = 1'b0;
        rreg(A_RAW, 32'h0, "R3 raw cleared by read");

        // R4: pop with more data behind
        chr_rdata = 8'h3C;
        chr_avail = 1'b1;
        rreg(A_RAW, 32'h0000_0050, "R5 raw second arrival");
        bus_rd(A_DR, 2'd0, 32'h0000_003C, 1'b1, "R3 byte data read");
        rreg(A_RAW, 32'h0000_0050, "R4 raw re-raised");

        // R7: clear with data present, then without
        wreg(A_CLR, 32'h0000_0050, "R7 clear with data");
        rreg(A_RAW, 32'h0000_0050, "R7 raw kept by data");
        chr_avail = 1'b0;
        wreg(A_CLR, 32'h0000_0010, "R7 clear bit4");
        rreg(A_RAW, 32'h0000_0040, "R7 raw after bit4 clear");
        wreg(A_CLR, 32'h0000_0040, "R7 clear bit6");
        rreg(A_RAW, 32'h0, "R7 raw all clear");

        // R6: transmit
        bus_wr(A_DR, 2'd2, 32'h1234_5641, 1'b1, 8'h41, "R6 data write");
        rreg(A_RAW, 32'h0000_0020, "R6 tx bit set");

        // R10 / R11: delayed interrupt
        rreg(A_MIS, 32'h0, "R10 masked with zero mask");
        wreg(A_MSK, 32'h0000_0020, "R11 wr mask tx");
        check_irq(1'b0, "R11 wait 0");
        check_irq(1'b0, "R11 wait 1");
        check_irq(1'b0, "R11 wait 2");
        check_irq(1'b1, "R11 raised");
        rreg(A_MIS, 32'h0000_0020, "R10 masked tx");
        wreg(A_CLR, 32'h0000_0020, "R11 clear tx");
        check_irq(1'b0, "R11 drop on clear");

        // R11: second source while waiting does not restart
        wreg(A_MSK, 32'h0000_0070, "R11 wr mask all");
        bus_wr(A_DR, 2'd0, 32'h0000_0077, 1'b1, 8'h77, "R6 byte data write");
        chr_avail = 1'b1;
        check_irq(1'b0, "R11 nr wait 0");
        check_irq(1'b0, "R11 nr wait 1");
        check_irq(1'b0, "R11 nr wait 2");
        check_irq(1'b1, "R11 nr raised");
        rreg(A_MIS, 32'h0000_0070, "R10 masked three bits");
        wreg(A_MSK, 32'h0, "R11 mask off");
        check_irq(1'b0, "R11 drop on mask");

        // R9: status reads zero, error-clear ignored
        chr_avail = 1'b0;
        wreg(A_CLR, 32'h0000_07FF, "R7 clear all");
        bus_wr(A_DR, 2'd2, 32'h0000_0033, 1'b1, 8'h33, "R6 data write 2");
        wreg(A_RSR, 32'hFFFF_FFFF, "R9 wr error clear");
        check_err(1'b0, "R9 error clear");
        rreg(A_RAW, 32'h0000_0020, "R9 raw unchanged");
        rreg(A_CTL, 32'h0000_0078, "R9 control unchanged");
        rreg(A_RSR, 32'h0, "R9 status read");

        // R12: DMA control
        rreg(A_DMA, 32'h0, "R12 dma read");
        wreg(A_DMA, 32'h0000_0008, "R12 wr reserved");
        check_err(1'b0, "R12 reserved bit");
        wreg(A_DMA, 32'h0000_0001, "R12 wr rx dma");
        check_err(1'b1, "R12 rx dma");
        check_err(1'b0, "R12 pulse ends");
        wreg(A_DMA, 32'h0000_0004, "R12 wr err dma");
        check_err(1'b1, "R12 err dma");

        // R13: bad accesses
        rreg(12'h008, 32'h0, "R13 unmapped read");
        check_err(1'b1, "R13 unmapped read");
        rreg(12'h031, 32'h0, "R13 unaligned read");
        check_err(1'b1, "R13 unaligned read");
        wreg(12'h050, 32'h1, "R13 unmapped write");
        check_err(1'b1, "R13 unmapped write");
        wreg(A_FLG, 32'h1, "R13 flag write");
        check_err(1'b1, "R13 flag write");
        rreg(A_CLR, 32'h0, "R13 clear read");
        check_err(1'b1, "R13 clear read");
        rreg(A_CTL, 32'h0000_0078, "R13 good read");
        check_err(1'b0, "R13 good read");

        repeat (2) @(negedge clk);
        check("scoreboard drained", sb.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule